// File: doc/BRIEF.md
# RC Channel Frame Decoder

This block turns a serial bit stream, already recovered by an upstream FSK demodulator, into a bank of eight 10-bit proportional channel values and eight on/off switch bits. Each bit arrives on `bitIn` and is qualified by a one-cycle `bitStb`. The decoder hunts for a 16-bit sync pattern. It then gathers nine 10-bit words, checks them against two check words, and commits the new values only when the whole frame is intact. Frames follow each other with no gap.

Each frame is a subframe, marked even or odd. One half of the channels receives absolute values. The other half is nudged by 5-bit deltas, each coding a signed power-of-two step. An even subframe carries absolute values for channels 1–4 and deltas for channels 5–8. An odd subframe swaps the two halves. A failsafe flag carried in each valid frame is held on an output until a later valid frame changes it. Two outputs report the result of each frame: `frameOk` pulses for a good frame and `frameErr` pulses for a rejected one.

Top module: `rc_frame_decoder`

## Requirements
- R1: After reset, every channel reads 512, the switches and `failsafe` read 0, and neither pulse output is high.
- R2: The decoder looks for the sync pattern 0xF0F0, sent MSB first, in the strobed bits. It then takes nine 10-bit words, each MSB first. A frame that follows immediately, with no gap, is also decoded, and bits before a sync pattern are ignored.
- R3: In word 0, bit 9 is the subframe flag (1 = odd) and bit 8 is the failsafe flag. Bits 7:0 go to `switches[7:0]`, with word bit i driving switch i.
- R4: Words 1–4 are absolute values. In an even subframe they go to channels 1–4 and in an odd subframe to channels 5–8, with word 1 feeding the lowest channel of that half. Channel n occupies `chanVals[10n-1:10n-10]`.
- R5: Words 5 and 6 each carry two 5-bit deltas for the other half. Bits 9:5 of word 5 go to its first channel, bits 4:0 of word 5 to its second, bits 9:5 of word 6 to its third and bits 4:0 of word 6 to its fourth. In each delta, bit 4 set means subtract and bits 3:0 hold k. A k of 0 means no change, whatever the sign, and any other k means a step of 2^(k-1).
- R6: The result of a delta is clamped to the range 0..1023.
- R7: Word 7 must equal the CRC-10 over words 0–6, sent MSB first, with polynomial x^10+x^9+x^5+x^4+x+1 and an all-ones seed. Word 8 must equal the bitwise complement of word 7.
- R8: When the check fails, the channels, switches and failsafe keep their values, `frameErr` pulses, and the next frame is still found.
- R9: The outputs and `frameOk` or `frameErr` change at the clock edge that samples the final strobed bit of word 8. Each pulse lasts one cycle.
- R10: `failsafe` takes the value of the failsafe flag of each valid frame and holds it between valid frames.
- R11: `frameOk` and `frameErr` are never high together, and the channel values change only in a cycle where `frameOk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Recovered data bit |
| bitStb | input | 1 | One-cycle strobe qualifying `bitIn` |
| chanVals | output | 80 | Eight 10-bit channel values, channel 1 in the low bits |
| switches | output | 8 | On/off switch channels |
| failsafe | output | 1 | Failsafe flag from the last valid frame |
| frameOk | output | 1 | One-cycle pulse after a valid frame |
| frameErr | output | 1 | One-cycle pulse after a frame that fails its check |

## Verification
Some rules hold on every cycle, and the bound checker tests those. The two pulses exclude each other and each lasts only one cycle. A pulse follows a strobed bit. Channels, switches and failsafe change only together with `frameOk`, and they stay frozen across `frameErr`. Other behaviour can only be shown by the bench's scenarios, which compare full decoded values against an independent model. These scenarios cover the even and odd routing, the delta fields, the clamps at both ends, and a k of zero with the sign set. They also cover the CRC rejection and recovery, sync after noise, and the exact cycle of the result pulse.

// File: rtl/rcdec_pkg.sv
package rcdec_pkg;
  localparam int WORD_W     = 10;
  localparam int NUM_WORDS  = 9;
  localparam int NUM_CH     = 8;
  localparam int ABS_N      = NUM_CH / 2;
  localparam int DELTA_W    = 5;
  localparam int DELTA_PER  = WORD_W / DELTA_W;
  localparam int DATA_WORDS = 1 + ABS_N + ABS_N / DELTA_PER;
  localparam int SYNC_W     = 16;
  localparam logic [SYNC_W-1:0] SYNC_PAT = 16'hF0F0;
  localparam logic [WORD_W-1:0] CRC_POLY = 10'h233;
  localparam int CNT_W      = $clog2(NUM_WORDS + 1);
  localparam int SUM_W      = WORD_W + 8;

  typedef struct packed {
    logic             syncShift;
    logic             frameStart;
    logic             dataBit;
    logic             crcBit;
    logic             wordEnd;
    logic [CNT_W-1:0] wordIdx;
    logic             frameEnd;
  } ctl_t;
endpackage

// File: rtl/rcdec_ctrl.sv
module rcdec_ctrl
  import rcdec_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic bitStb,
  input  logic syncHit,
  output ctl_t ctl
);
  typedef enum logic { HUNT, GATHER } state_t;
  state_t state;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] wordCnt;

  always_comb begin
    ctl = '0;
    ctl.wordIdx = wordCnt;
    if (bitStb) begin
      if (state == HUNT) begin
        ctl.syncShift  = 1'b1;
        ctl.frameStart = syncHit;
      end else begin
        ctl.dataBit  = 1'b1;
        ctl.crcBit   = (wordCnt < CNT_W'(DATA_WORDS));
        ctl.wordEnd  = (bitCnt == CNT_W'(WORD_W - 1));
        ctl.frameEnd = ctl.wordEnd && (wordCnt == CNT_W'(NUM_WORDS - 1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= HUNT;
      bitCnt  <= '0;
      wordCnt <= '0;
    end else if (ctl.frameStart) begin
      state   <= GATHER;
      bitCnt  <= '0;
      wordCnt <= '0;
    end else if (ctl.dataBit) begin
      if (ctl.wordEnd) begin
        bitCnt <= '0;
        if (ctl.frameEnd) state <= HUNT;
        else wordCnt <= wordCnt + 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rcdec_dp.sv
module rcdec_dp
  import rcdec_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_VAL = 10'd512
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           bitIn,
  input  ctl_t                           ctl,
  output logic                           syncHit,
  output logic [NUM_CH-1:0][WORD_W-1:0]  chanVals,
  output logic [NUM_CH-1:0]              switches,
  output logic                           failsafe,
  output logic                           frameOk,
  output logic                           frameErr
);
  localparam logic [SUM_W-1:0] MAX_VAL = SUM_W'((1 << WORD_W) - 1);

  logic [SYNC_W-1:0] syncSh, syncNext;
  logic [WORD_W-1:0] wordSh, wordNext, crc, crcNext;
  logic [WORD_W-1:0] words [0:DATA_WORDS];
  logic [NUM_CH-1:0][WORD_W-1:0] chanNext;
  logic crcPass, oddSub;

  function automatic logic [WORD_W-1:0] applyDelta(input logic [WORD_W-1:0] old,
                                                   input logic [DELTA_W-1:0] d);
    logic [SUM_W-1:0] base, mag, sum;
    logic [DELTA_W-2:0] k;
    k    = d[DELTA_W-2:0];
    base = SUM_W'(old);
    mag  = (k == '0) ? '0 : (SUM_W'(1) << (k - 1'b1));
    sum  = base + mag;
    if (d[DELTA_W-1]) return (base < mag) ? '0 : WORD_W'(base - mag);
    else              return (sum > MAX_VAL) ? WORD_W'(MAX_VAL) : WORD_W'(sum);
  endfunction

  assign syncNext = {syncSh[SYNC_W-2:0], bitIn};
  assign syncHit  = (syncNext == SYNC_PAT);
  assign wordNext = {wordSh[WORD_W-2:0], bitIn};
  assign crcNext  = {crc[WORD_W-2:0], 1'b0} ^ ((crc[WORD_W-1] ^ bitIn) ? CRC_POLY : '0);
  assign crcPass  = (words[DATA_WORDS] == crc) && (wordNext == ~crc);
  assign oddSub   = words[0][WORD_W-1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int  POS     = c % ABS_N;
    localparam bit  IS_HIGH = (c / ABS_N) == 1;
    localparam int  DWORD   = 1 + ABS_N + POS / DELTA_PER;
    localparam int  DLSB    = (DELTA_PER - 1 - POS % DELTA_PER) * DELTA_W;
    logic [DELTA_W-1:0] dField;
    assign dField = words[DWORD][DLSB +: DELTA_W];
    assign chanNext[c] = (oddSub == IS_HIGH) ? words[1 + POS]
                                             : applyDelta(chanVals[c], dField);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncSh <= '0;
      wordSh <= '0;
      crc    <= '1;
      for (int i = 0; i <= DATA_WORDS; i++) words[i] <= '0;
    end else begin
      if (ctl.frameStart)     syncSh <= '0;
      else if (ctl.syncShift) syncSh <= syncNext;
      if (ctl.dataBit) wordSh <= wordNext;
      if (ctl.frameStart)  crc <= '1;
      else if (ctl.crcBit) crc <= crcNext;
      if (ctl.wordEnd && ctl.wordIdx <= CNT_W'(DATA_WORDS))
        words[ctl.wordIdx[$clog2(DATA_WORDS+1)-1:0]] <= wordNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanVals <= {NUM_CH{RESET_VAL}};
      switches <= '0;
      failsafe <= 1'b0;
      frameOk  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      frameOk  <= ctl.frameEnd && crcPass;
      frameErr <= ctl.frameEnd && !crcPass;
      if (ctl.frameEnd && crcPass) begin
        chanVals <= chanNext;
        switches <= words[0][NUM_CH-1:0];
        failsafe <= words[0][WORD_W-2];
      end
    end
  end
endmodule

// File: rtl/rc_frame_decoder.sv
module rc_frame_decoder
  import rcdec_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_VAL = 10'd512
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          bitIn,
  input  logic                          bitStb,
  output logic [NUM_CH-1:0][WORD_W-1:0] chanVals,
  output logic [NUM_CH-1:0]             switches,
  output logic                          failsafe,
  output logic                          frameOk,
  output logic                          frameErr
);
  ctl_t ctl;
  logic syncHit;

  rcdec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bitStb(bitStb), .syncHit(syncHit), .ctl(ctl)
  );

  rcdec_dp #(.RESET_VAL(RESET_VAL)) u_dp (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .ctl(ctl), .syncHit(syncHit),
    .chanVals(chanVals), .switches(switches), .failsafe(failsafe),
    .frameOk(frameOk), .frameErr(frameErr)
  );
endmodule

// File: rtl/rcdec_chk.sv
module rcdec_chk
  import rcdec_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          bitStb,
  input logic [NUM_CH-1:0][WORD_W-1:0] chanVals,
  input logic [NUM_CH-1:0]             switches,
  input logic                          failsafe,
  input logic                          frameOk,
  input logic                          frameErr
);
  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(frameOk && frameErr));

  // R11
  chan_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chanVals) |-> frameOk);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> ($stable(chanVals) && $stable(switches) && $stable(failsafe)));

  // R10
  fs_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(failsafe) |-> frameOk);

  // R9
  ok_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameOk || frameErr) |=> !(frameOk || frameErr));

  // R9
  after_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameOk || frameErr) |-> $past(bitStb));
endmodule

bind rc_frame_decoder rcdec_chk u_chk (
  .clk(clk), .rstN(rstN), .bitStb(bitStb), .chanVals(chanVals),
  .switches(switches), .failsafe(failsafe), .frameOk(frameOk), .frameErr(frameErr)
);

// File: tb/tb_rc_frame_decoder.sv
module tb_rc_frame_decoder;
  logic clk = 0;
  logic rstN = 0;
  logic bitIn = 0;
  logic bitStb = 0;
  logic [7:0][9:0] chanVals;
  logic [7:0] switches;
  logic failsafe, frameOk, frameErr;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int model [8];

  typedef struct {
    bit              ok;
    logic [7:0][9:0] ch;
    logic [7:0]      sw;
    bit              fs;
    string           tag;
  } exp_t;
  exp_t q[$];
  bit fsModel = 0;
  logic [7:0] swModel = 0;

  always #10 clk = ~clk;

  rc_frame_decoder dut (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitStb(bitStb), .chanVals(chanVals),
    .switches(switches), .failsafe(failsafe), .frameOk(frameOk), .frameErr(frameErr)
  );

  task automatic check(input bit cond, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] crc10(input logic [69:0] s);
    logic [9:0] c;
    logic fb;
    c = '1;
    for (int i = 69; i >= 0; i--) begin
      fb = c[9] ^ s[i];
      c = {c[8:0], 1'b0};
      if (fb) c = c ^ 10'h233;
    end
    return c;
  endfunction

  function automatic int stepOf(input int old, input logic [4:0] d);
    int mag, r;
    mag = (d[3:0] == 0) ? 0 : (1 << (d[3:0] - 1));
    r = d[4] ? old - mag : old + mag;
    if (r < 0) r = 0;
    if (r > 1023) r = 1023;
    return r;
  endfunction

  task automatic sendBit(input logic b, input bit last);
    @(negedge clk);
    bitIn = b; bitStb = 1;
    @(negedge clk);
    bitStb = 0;
    if (last) begin
      // R9: result pulse in the cycle right after the final strobed bit
      check(frameOk || frameErr, "R9", "pulse after last bit", frameOk | frameErr, 1);
      @(negedge clk);
      check(!(frameOk || frameErr), "R9", "pulse width one cycle", frameOk | frameErr, 0);
    end
  endtask

  task automatic sendFrame(input bit odd, input bit fs, input logic [7:0] sw,
                           input logic [9:0] a0, a1, a2, a3,
                           input logic [4:0] d0, d1, d2, d3,
                           input bit corrupt, input string tag);
    logic [9:0] w [9];
    logic [9:0] av [4];
    logic [4:0] dv [4];
    exp_t e;
    int base, dbase;
    av[0] = a0; av[1] = a1; av[2] = a2; av[3] = a3;
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
    w[0] = {odd, fs, sw};
    w[1] = a0; w[2] = a1; w[3] = a2; w[4] = a3;
    w[5] = {d0, d1}; w[6] = {d2, d3};
    w[7] = crc10({w[0], w[1], w[2], w[3], w[4], w[5], w[6]});
    w[8] = ~w[7];
    if (corrupt) w[8][0] = ~w[8][0];
    if (!corrupt) begin
      base  = odd ? 4 : 0;
      dbase = odd ? 0 : 4;
      for (int i = 0; i < 4; i++) begin
        model[base + i]  = av[i];
        model[dbase + i] = stepOf(model[dbase + i], dv[i]);
      end
      fsModel = fs;
      swModel = sw;
    end
    e.ok = !corrupt;
    for (int i = 0; i < 8; i++) e.ch[i] = model[i][9:0];
    e.sw = swModel;
    e.fs = fsModel;
    e.tag = tag;
    q.push_back(e);
    for (int i = 15; i >= 0; i--) sendBit(16'hF0F0 >> i, 0);
    for (int k = 0; k < 9; k++)
      for (int i = 9; i >= 0; i--) sendBit(w[k][i], (k == 8) && (i == 0));
  endtask

  // monitor: pop expected results as the design reports frames
  always @(negedge clk) begin
    if (rstN && (frameOk || frameErr)) begin
      if (q.size() == 0) begin
        check(0, "R2", "unexpected frame pulse", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(frameOk == e.ok, e.tag, "ok pulse kind", frameOk, e.ok);
        for (int i = 0; i < 8; i++)
          check(chanVals[i] == e.ch[i], e.tag, $sformatf("channel %0d", i + 1),
                chanVals[i], e.ch[i]);
        check(switches == e.sw, e.tag, "switches", switches, e.sw);
        check(failsafe == e.fs, e.tag, "failsafe", failsafe, e.fs);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 512;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 8; i++)
      check(chanVals[i] == 10'd512, "R1", "reset channel", chanVals[i], 512);
    check(switches == 0 && !failsafe, "R1", "reset switches/failsafe", {switches, failsafe}, 0);
    check(!frameOk && !frameErr, "R1", "reset pulses", {frameOk, frameErr}, 0);

    // R2: noise bits before the first sync are ignored
    for (int i = 0; i < 11; i++) sendBit(i % 3 == 0, 0);
    check(!frameOk && !frameErr, "R2", "no pulse on noise", {frameOk, frameErr}, 0);

    // R4 / R5 / R6: even subframe, deltas on 5..8 incl. upper clamp
    sendFrame(0, 0, 8'hA5, 10'd100, 10'd200, 10'd300, 10'd400,
              5'b00001, 5'b10011, 5'b00000, 5'b01010, 0, "R4");
    // R5: odd subframe, deltas on 1..4, sign with k=0 means no change
    sendFrame(1, 0, 8'h5A, 10'd1000, 10'd5, 10'd1020, 10'd3,
              5'b00111, 5'b11000, 5'b11111, 5'b10000, 0, "R5");
    // R6: clamps at both ends
    sendFrame(0, 0, 8'h0F, 10'd1023, 10'd0, 10'd50, 10'd60,
              5'b01111, 5'b10011, 5'b00011, 5'b10100, 0, "R6");
    // R7 / R8: broken complement word is rejected, values held
    sendFrame(1, 1, 8'hFF, 10'd7, 10'd8, 10'd9, 10'd10,
              5'b00101, 5'b00101, 5'b00101, 5'b00101, 1, "R8");
    // R8 / R10: next frame follows with no gap and is decoded; failsafe set
    sendFrame(0, 1, 8'hFF, 10'd11, 10'd22, 10'd33, 10'd44,
              5'b10001, 5'b00010, 5'b10010, 5'b00001, 0, "R10");
    // R3 / R10: odd subframe clears failsafe, new switch pattern
    sendFrame(1, 0, 8'h3C, 10'd600, 10'd700, 10'd800, 10'd900,
              5'b00100, 5'b10100, 5'b00000, 5'b01001, 0, "R3");
    // R7: a second rejected frame, then recovery
    sendFrame(0, 1, 8'h00, 10'd1, 10'd2, 10'd3, 10'd4,
              5'b0, 5'b0, 5'b0, 5'b0, 1, "R7");
    sendFrame(0, 0, 8'h81, 10'd512, 10'd256, 10'd128, 10'd64,
              5'b00110, 5'b10110, 5'b01000, 5'b11000, 0, "R2");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R2", "all frames reported", q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule